// File: doc/BRIEF.md
# Hidden Address Latch Tracker

This block shadows the concealed 16-bit address latch of an 8-bit processor core. Programs cannot read that latch, but its value leaks into undocumented flag bits. The surrounding core tells the block which kind of instruction has just reached the point where the latch changes. It does this with a one-cycle strobe per instruction class, alongside the operands that the class needs:

- the BC, DE and HL register pairs;
- the opcode byte;
- the absolute address taken from the instruction stream;
- the computed branch target;
- the word popped from the stack;
- the source operand of the 16-bit ALU.

On that strobe, the block reloads the latch by a rule that belongs to the class. Some classes copy an operand. Some copy an operand plus or minus one. Some step the latch's own value up or down. All arithmetic on the latch wraps modulo 65536.

The result is presented as a plain registered value with a one-cycle valid pulse. The strobe and operand inputs form a push-only stream with no back-pressure: the block accepts every strobe in the cycle it is seen and never stalls the core. If several class strobes are raised together, a fixed priority picks exactly one of them. Class bit 0 has the highest priority. With no strobe raised, the latch keeps its value. For a block output step, the core presents BC as it stands after the transfer.

Top module: `mp_tracker`

## Requirements
- R1: A synchronous reset drives `ptr_q` to 0x0000 and `ptr_vld` to 0 at the next clock edge, whatever the strobes carry.
- R2: A clock edge with no bit of `cls_req` set leaves `ptr_q` unchanged and drives `ptr_vld` to 0. A clock edge with any bit set loads the new value into `ptr_q` and drives `ptr_vld` to 1, both visible right after that edge.
- R3: Restart class (bit 0): the latch becomes `op_code & 0x38`, zero-extended to 16 bits.
- R4: Indirect accumulator access class through BC (bit 1) copies `pair_bc`. The same class through DE (bit 2) copies `pair_de`.
- R5: Absolute-address accumulator load class (bit 3): the latch becomes `imm_addr`.
- R6: Return class (bit 4) and stack-top exchange class (bit 6): the latch becomes `pop_word`.
- R7: Relative branch and count-and-branch class (bit 5): the latch becomes `jmp_tgt`.
- R8: 16-bit add, add-with-carry and subtract-with-carry class (bit 7): the latch becomes `alu_src`.
- R9: Block compare class (bit 8): the latch becomes its own value plus 1 when `blk_fwd` is 1, or minus 1 when it is 0, wrapping at both ends.
- R10: Block input class (bit 9) and block output class (bit 10): the latch becomes `pair_bc` plus 1 when `blk_fwd` is 1, or minus 1 when it is 0, wrapping.
- R11: Nibble rotate class (bit 11): the latch becomes `pair_hl` plus 1, wrapping; `blk_fwd` has no effect.
- R12: When several `cls_req` bits are set, only the lowest-numbered set bit is applied, using the bit assignments of R3 to R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_req | input | 12 | One-cycle instruction-class strobes, bit 0 highest priority |
| blk_fwd | input | 1 | Block-operation direction, 1 = ascending |
| op_code | input | 8 | Current opcode byte |
| pair_bc | input | 16 | BC register pair |
| pair_de | input | 16 | DE register pair |
| pair_hl | input | 16 | HL register pair |
| imm_addr | input | 16 | Absolute address fetched from the instruction stream |
| jmp_tgt | input | 16 | Computed relative branch target |
| pop_word | input | 16 | Word popped from the stack |
| alu_src | input | 16 | Source operand of the 16-bit ALU |
| ptr_q | output | 16 | Current latch value |
| ptr_vld | output | 1 | Pulses for one cycle after each accepted strobe |

## Verification
There is exactly one register between a strobe and its result. The new latch value and the valid pulse both appear right after the clock edge that sees the strobe. A hold or a reset is likewise due after one edge.

The bench drives each strobe pattern on the falling edge. It computes the expected value before the rising edge, from the bench's own copy of the previous latch value. It compares one time unit after that rising edge, and then drops the strobes.

The stimulus covers the following:
- every opcode for the restart class;
- every pair of simultaneous classes for priority;
- operand sweeps, including the wrap points 0x0000 and 0xFFFF, in both directions.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int NCLS = 12;
  localparam int OPW  = 8;
  localparam logic [OPW-1:0] RST_MASK = 8'h38;

  // class strobe bit positions (lower index = higher priority)
  localparam int C_RST   = 0;
  localparam int C_IBC   = 1;
  localparam int C_IDE   = 2;
  localparam int C_ABS   = 3;
  localparam int C_RET   = 4;
  localparam int C_JREL  = 5;
  localparam int C_EXSP  = 6;
  localparam int C_AR16  = 7;
  localparam int C_BCMP  = 8;
  localparam int C_BIN   = 9;
  localparam int C_BOUT  = 10;
  localparam int C_NROT  = 11;

  typedef logic [NCLS-1:0] cls_vec_t;
endpackage

// File: rtl/mp_grant.sv
module mp_grant #(
  parameter int N = 12
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  // Scan from the highest-priority bit: a bit is granted only if no
  // lower-numbered bit has been seen set.
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chain
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
    end
  endgenerate

  assign any = seen[N];
endmodule

// File: rtl/mp_step.sv
module mp_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         up,
  output logic [W-1:0] res
);
  // Adding all-ones is a decrement; both directions wrap modulo 2**W.
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MONE = {W{1'b1}};

  assign res = val + (up ? ONE : MONE);
endmodule

// File: rtl/mp_select.sv
module mp_select
  import mp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [NCLS-1:0] gnt,
  input  logic            fwd,
  input  logic [OPW-1:0]  opc,
  input  logic [AW-1:0]   cur,
  input  logic [AW-1:0]   bc,
  input  logic [AW-1:0]   de,
  input  logic [AW-1:0]   hl,
  input  logic [AW-1:0]   imm,
  input  logic [AW-1:0]   tgt,
  input  logic [AW-1:0]   pop,
  input  logic [AW-1:0]   src,
  output logic [AW-1:0]   nxt
);
  logic [AW-1:0] cur_step;
  logic [AW-1:0] bc_step;
  logic [AW-1:0] hl_inc;
  logic [AW-1:0] cand [NCLS];
  logic [AW-1:0] part [NCLS+1];

  // latch +/- 1 for block compare
  mp_step #(.W(AW)) u_cur (.val(cur), .up(fwd),  .res(cur_step));
  // BC +/- 1 for block input and output
  mp_step #(.W(AW)) u_bc  (.val(bc),  .up(fwd),  .res(bc_step));
  // HL + 1 for nibble rotates
  mp_step #(.W(AW)) u_hl  (.val(hl),  .up(1'b1), .res(hl_inc));

  always_comb begin
    cand[C_RST]  = AW'(opc & RST_MASK);
    cand[C_IBC]  = bc;
    cand[C_IDE]  = de;
    cand[C_ABS]  = imm;
    cand[C_RET]  = pop;
    cand[C_JREL] = tgt;
    cand[C_EXSP] = pop;
    cand[C_AR16] = src;
    cand[C_BCMP] = cur_step;
    cand[C_BIN]  = bc_step;
    cand[C_BOUT] = bc_step;
    cand[C_NROT] = hl_inc;
  end

  // AND-OR mux: the grant is one-hot or zero
  assign part[0] = '0;
  genvar k;
  generate
    for (k = 0; k < NCLS; k++) begin : g_mux
      assign part[k+1] = part[k] | (cand[k] & {AW{gnt[k]}});
    end
  endgenerate

  assign nxt = part[NCLS];
endmodule

// File: rtl/mp_tracker.sv
module mp_tracker
  import mp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [mp_pkg::NCLS-1:0] cls_req,
  input  logic                  blk_fwd,
  input  logic [mp_pkg::OPW-1:0]  op_code,
  input  logic [AW-1:0]         pair_bc,
  input  logic [AW-1:0]         pair_de,
  input  logic [AW-1:0]         pair_hl,
  input  logic [AW-1:0]         imm_addr,
  input  logic [AW-1:0]         jmp_tgt,
  input  logic [AW-1:0]         pop_word,
  input  logic [AW-1:0]         alu_src,
  output logic [AW-1:0]         ptr_q,
  output logic                  ptr_vld
);
  logic [NCLS-1:0] gnt;
  logic            any_req;
  logic [AW-1:0]   ptr_nxt;

  mp_grant #(.N(NCLS)) u_grant (
    .req (cls_req),
    .gnt (gnt),
    .any (any_req)
  );

  mp_select #(.AW(AW)) u_sel (
    .gnt (gnt),
    .fwd (blk_fwd),
    .opc (op_code),
    .cur (ptr_q),
    .bc  (pair_bc),
    .de  (pair_de),
    .hl  (pair_hl),
    .imm (imm_addr),
    .tgt (jmp_tgt),
    .pop (pop_word),
    .src (alu_src),
    .nxt (ptr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      ptr_vld <= 1'b0;
    end else begin
      ptr_vld <= any_req;
      if (any_req) ptr_q <= ptr_nxt;
    end
  end
endmodule

// File: rtl/mp_tracker_chk.sv
module mp_tracker_chk #(
  parameter int AW = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [mp_pkg::NCLS-1:0] cls_req,
  input logic                    blk_fwd,
  input logic [mp_pkg::OPW-1:0]  op_code,
  input logic [AW-1:0]           pair_bc,
  input logic [AW-1:0]           pair_de,
  input logic [AW-1:0]           pair_hl,
  input logic [AW-1:0]           imm_addr,
  input logic [AW-1:0]           jmp_tgt,
  input logic [AW-1:0]           pop_word,
  input logic [AW-1:0]           alu_src,
  input logic [AW-1:0]           ptr_q,
  input logic                    ptr_vld
);
  logic rst_d;

  always_ff @(posedge clk) rst_d <= rst;

  // R1: the cycle after reset shows a cleared latch and no valid pulse
  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      assert_reset_clear_R1: assert (ptr_q == '0 && !ptr_vld);
    end
  end

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (cls_req == '0) |=> ($stable(ptr_q) && !ptr_vld));

  assert_vld_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (cls_req != '0) |=> ptr_vld);

  assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
    cls_req[0] |=> (ptr_q == AW'($past(op_code) & 8'h38)));

  assert_bc_copy_R4: assert property (@(posedge clk) disable iff (rst)
    (cls_req[1:0] == 2'b10) |=> (ptr_q == $past(pair_bc)));

  assert_blkcmp_R9: assert property (@(posedge clk) disable iff (rst)
    (cls_req == 12'h100) |=>
      (ptr_q == ($past(blk_fwd) ? $past(ptr_q) + AW'(1) : $past(ptr_q) - AW'(1))));

  assert_nibrot_R11: assert property (@(posedge clk) disable iff (rst)
    (cls_req == 12'h800) |=> (ptr_q == $past(pair_hl) + AW'(1)));
endmodule

bind mp_tracker mp_tracker_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_mp_tracker.sv
module tb_mp_tracker;
  localparam int PERIOD = 10;
  localparam int AW = 16;
  localparam int NC = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] cls_req = '0;
  logic          blk_fwd = 1'b1;
  logic [7:0]    op_code = '0;
  logic [AW-1:0] pair_bc = '0, pair_de = '0, pair_hl = '0;
  logic [AW-1:0] imm_addr = '0, jmp_tgt = '0, pop_word = '0, alu_src = '0;
  logic [AW-1:0] ptr_q;
  logic          ptr_vld;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [AW-1:0] exp_q = '0;

  always #(PERIOD/2) clk = ~clk;

  mp_tracker #(.AW(AW)) dut (.*);

  function automatic logic [AW-1:0] model(input int k, input logic [AW-1:0] cur);
    case (k)
      0:  return {8'h00, op_code & 8'h38};
      1:  return pair_bc;
      2:  return pair_de;
      3:  return imm_addr;
      4, 6: return pop_word;
      5:  return jmp_tgt;
      7:  return alu_src;
      8:  return blk_fwd ? cur + 16'd1 : cur - 16'd1;
      9, 10: return blk_fwd ? pair_bc + 16'd1 : pair_bc - 16'd1;
      default: return pair_hl + 16'd1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] e, input logic ev);
    tests++;
    if (ptr_q !== e || ptr_vld !== ev) begin
      fails++;
      $display("FAIL %s: ptr_q=%h vld=%b expected ptr_q=%h vld=%b", tag, ptr_q, ptr_vld, e, ev);
    end
  endtask

  // Drive on the falling edge, predict, sample 1 unit after the rising edge.
  task automatic step(input logic [NC-1:0] r, input string tag);
    logic [AW-1:0] nxt;
    @(negedge clk);
    cls_req = r;
    nxt = exp_q;
    for (int i = NC - 1; i >= 0; i--) if (r[i]) nxt = model(i, exp_q);
    @(posedge clk);
    #1;
    check(tag, nxt, r != '0);
    exp_q = nxt;
    cls_req = '0;
  endtask

  task automatic rand_ops();
    pair_bc = 16'($urandom); pair_de = 16'($urandom); pair_hl = 16'($urandom);
    imm_addr = 16'($urandom); jmp_tgt = 16'($urandom);
    pop_word = 16'($urandom); alu_src = 16'($urandom);
    op_code = 8'($urandom); blk_fwd = 1'($urandom);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset with strobes active still clears
    cls_req = '1;
    pair_bc = 16'hBEEF;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset", 16'h0000, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    cls_req = '0;
    exp_q = '0;

    // R2: idle cycles hold
    step('0, "R2 idle");
    rand_ops();
    step(12'h002, "R4 bc");
    step('0, "R2 hold");
    step('0, "R2 hold2");

    // R1: reset from a nonzero value
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset nonzero", 16'h0000, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    exp_q = '0;

    // R3: every opcode
    for (int o = 0; o < 256; o++) begin
      op_code = 8'(o);
      pair_bc = 16'($urandom);
      step(12'h001, "R3 restart");
    end

    // single-class sweeps with random operands
    for (int n = 0; n < 40; n++) begin
      rand_ops();
      step(12'h002, "R4 bc");
      step(12'h004, "R4 de");
      step(12'h008, "R5 abs");
      step(12'h010, "R6 ret");
      step(12'h040, "R6 exsp");
      step(12'h020, "R7 jrel");
      step(12'h080, "R8 arith");
      step(12'h100, "R9 blkcmp");
      step(12'h200, "R10 blkin");
      step(12'h400, "R10 blkout");
      step(12'h800, "R11 nibrot");
      step('0, "R2 idle");
    end

    // R9 wrap both ways
    pop_word = 16'hFFFF;
    step(12'h010, "R6 ret");
    blk_fwd = 1'b1;
    step(12'h100, "R9 wrap up");
    blk_fwd = 1'b0;
    step(12'h100, "R9 wrap down");
    step(12'h100, "R9 down again");

    // R10 wrap both ways
    pair_bc = 16'hFFFF;
    blk_fwd = 1'b1;
    step(12'h200, "R10 in wrap up");
    pair_bc = 16'h0000;
    blk_fwd = 1'b0;
    step(12'h400, "R10 out wrap down");
    blk_fwd = 1'b1;
    step(12'h400, "R10 out up");

    // R11 wrap, direction ignored
    pair_hl = 16'hFFFF;
    blk_fwd = 1'b0;
    step(12'h800, "R11 wrap fwd0");
    pair_hl = 16'h1234;
    step(12'h800, "R11 fwd0");

    // R12: every pair of simultaneous classes
    for (int i = 0; i < NC; i++) begin
      for (int j = i + 1; j < NC; j++) begin
        rand_ops();
        step((12'h1 << i) | (12'h1 << j), "R12 pair");
      end
    end
    rand_ops();
    step(12'hFFF, "R12 all");
    step(12'hF00, "R12 upper");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule